// File: doc/BRIEF.md
# Exception entry sequencer

This block sits beside a CPU pipeline and starts exception handling. The decode stage reports each decoded instruction with flags that say whether its opcode is undefined, whether it belongs to the floating-point class or to the register-bank class, and whether it sits in the slot right after a delayed branch. The execute stage reports integer divide faults. The sequencer uses its configuration inputs to decide which of these instructions are undefined. When the FPU is missing or held in standby, floating-point opcodes count as undefined. When no register bank is built, bank opcodes count as undefined. It then sorts the fault into one of three kinds and accepts at most one of them.

After accepting a fault, the block reads the handler address from a vector table through a single memory port. It then pushes the status register and the saved program counter onto the stack, lowering the stack pointer by 4 before each push. Last, it loads the fetch unit with the handler address. This is a plain jump with no delay slot. The block holds `busy` high from the cycle after acceptance until that jump, and it ignores any new request while `busy` is high.

Top module: `exc_entry_seq`

## Requirements
- R1: Undefined code outside a delay slot raises a general illegal exception: vector number VEC_GEN (default 4), saved PC equal to `dec_pc`.
- R2: Undefined code inside a delay slot raises a slot illegal exception: vector number VEC_SLOT (default 6), saved PC equal to `dec_pc` minus INSN_BYTES (default 2), which is the address of the owning branch.
- R3: A floating-point class opcode (`dec_fpu_op`=1) counts as undefined when `cfg_fpu_present`=0 or `cfg_fpu_standby`=1. Otherwise it raises nothing.
- R4: A register-bank class opcode (`dec_bank_op`=1) counts as undefined when `cfg_bank_present`=0. Otherwise it raises nothing.
- R5: `div_exc_req`=1 raises a divide exception: vector number VEC_DIV (default 9), saved PC equal to `div_pc`.
- R6: When requests arrive in the same cycle, the priority is general illegal, then slot illegal, then divide. Only the winner is taken, and the losers are dropped.
- R7: The vector read address is `vec_base` + 4 × vector number. The read data becomes `pc_new`.
- R8: Accesses run in a fixed order: first the vector read (`mem_we`=0), then a write of `cur_sr` to `cur_sp`-4, then a write of the saved PC to `cur_sp`-8. Only one access is outstanding at a time. Each access holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack`.
- R9: `sp_wr_en` pulses once for each acknowledged push. It carries `cur_sp`-4 and then `cur_sp`-8, so the final stack pointer is `cur_sp`-8.
- R10: `pc_load` is a one-cycle pulse in the cycle after the last push is acknowledged. `busy` is high from the cycle after acceptance through that pulse, and low in the cycle after it.
- R11: Requests of any kind that arrive while `busy`=1 are ignored and produce no later exception.
- R12: During and after reset, `busy`, `mem_req`, `pc_load` and `sp_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage presents an instruction |
| dec_undef | input | 1 | Opcode is undefined in every configuration |
| dec_fpu_op | input | 1 | Opcode belongs to the floating-point class |
| dec_bank_op | input | 1 | Opcode belongs to the register-bank class |
| dec_in_slot | input | 1 | Instruction sits in a delayed-branch slot |
| dec_pc | input | 32 | Address of the decoded instruction |
| cfg_fpu_present | input | 1 | FPU is built |
| cfg_fpu_standby | input | 1 | FPU is held in standby |
| cfg_bank_present | input | 1 | Register bank is built |
| div_exc_req | input | 1 | Integer divide fault from execute |
| div_pc | input | 32 | Address of the faulting divide |
| cur_sr | input | 32 | Current status register |
| cur_sp | input | 32 | Current stack pointer |
| vec_base | input | 32 | Vector table base address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| sp_wr_en | output | 1 | Stack pointer update strobe |
| sp_wr_data | output | 32 | New stack pointer value |
| pc_load | output | 1 | Redirect fetch this cycle |
| pc_new | output | 32 | Handler address |
| busy | output | 1 | Entry sequence in progress |

## Verification
A request that is present at a clock edge while the block is idle raises `busy` and starts the vector read from the next cycle on. Each push starts in the cycle after the previous access is acknowledged, and `sp_wr_en` is high in the same cycle as the acknowledge that completes a push. `pc_load` follows one cycle after the last acknowledge. The bench drives inputs and the memory acknowledge at the falling edge and samples outputs 1 ns after it. It records every access and strobe in that window and compares the log with values computed from the requirements once `busy` has fallen. Acknowledge latency is random, so the checks depend on event order and not on fixed cycle counts.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN = 32;
  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_VEC, ST_PSR, ST_PPC, ST_JMP
  } seq_st_e;

  typedef enum logic [1:0] {
    EX_NONE, EX_GEN, EX_SLOT, EX_DIV
  } exc_kind_e;

  // Vector table slot address: base plus four bytes per vector number
  function automatic word_t vec_addr(input word_t base, input word_t num);
    return base + (num << 2);
  endfunction

  // Address of the n-th pre-decremented push below sp
  function automatic word_t push_addr(input word_t sp, input int unsigned n);
    return sp - word_t'(4 * n);
  endfunction
endpackage

// File: rtl/exc_classify.sv
module exc_classify (
  input  logic dec_valid,
  input  logic dec_undef,
  input  logic dec_fpu_op,
  input  logic dec_bank_op,
  input  logic dec_in_slot,
  input  logic cfg_fpu_present,
  input  logic cfg_fpu_standby,
  input  logic cfg_bank_present,
  output logic gen_hit,
  output logic slot_hit
);
  logic fpu_unusable;
  logic undef_eff;

  always_comb begin
    fpu_unusable = !cfg_fpu_present || cfg_fpu_standby;
    undef_eff    = dec_valid && (dec_undef
                                 || (dec_fpu_op && fpu_unusable)
                                 || (dec_bank_op && !cfg_bank_present));
    gen_hit      = undef_eff && !dec_in_slot;
    slot_hit     = undef_eff && dec_in_slot;
  end
endmodule

// File: rtl/exc_capture.sv
module exc_capture
  import exc_pkg::*;
#(
  parameter int VW         = 8,
  parameter int INSN_BYTES = 2,
  parameter logic [VW-1:0] VEC_GEN  = 8'd4,
  parameter logic [VW-1:0] VEC_SLOT = 8'd6,
  parameter logic [VW-1:0] VEC_DIV  = 8'd9
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  idle,
  input  logic  gen_hit,
  input  logic  slot_hit,
  input  logic  div_req,
  input  word_t dec_pc,
  input  word_t div_pc,
  input  word_t sr_in,
  input  word_t sp_in,
  input  word_t vbr_in,
  output logic  accept,
  output word_t cap_vec,
  output word_t cap_pc,
  output word_t cap_sr,
  output word_t cap_sp,
  output word_t cap_vbr
);
  localparam word_t SLOT_BACK = word_t'(INSN_BYTES);

  exc_kind_e pick;
  word_t     pick_vec;
  word_t     pick_pc;

  always_comb begin
    pick     = EX_NONE;
    pick_vec = '0;
    pick_pc  = '0;
    if (gen_hit) begin
      pick = EX_GEN;  pick_vec = word_t'(VEC_GEN);  pick_pc = dec_pc;
    end else if (slot_hit) begin
      pick = EX_SLOT; pick_vec = word_t'(VEC_SLOT); pick_pc = dec_pc - SLOT_BACK;
    end else if (div_req) begin
      pick = EX_DIV;  pick_vec = word_t'(VEC_DIV);  pick_pc = div_pc;
    end
    accept = idle && (pick != EX_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_vec <= '0; cap_pc <= '0; cap_sr <= '0; cap_sp <= '0; cap_vbr <= '0;
    end else if (accept) begin
      cap_vec <= pick_vec;
      cap_pc  <= pick_pc;
      cap_sr  <= sr_in;
      cap_sp  <= sp_in;
      cap_vbr <= vbr_in;
    end
  end

  // R11: the captured record does not move while a sequence runs
  a_r11_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(cap_pc) && $stable(cap_vec) && $stable(cap_sp));

  // R6: a decode illegal beats a same-cycle divide
  a_r6_illegal_first: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && gen_hit && div_req) |=> cap_vec == word_t'(VEC_GEN));
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  word_t cap_vec,
  input  word_t cap_pc,
  input  word_t cap_sr,
  input  word_t cap_sp,
  input  word_t cap_vbr,
  input  logic  mem_ack,
  input  word_t mem_rdata,
  output logic  idle,
  output logic  busy,
  output logic  mem_req,
  output logic  mem_we,
  output word_t mem_addr,
  output word_t mem_wdata,
  output logic  sp_wr_en,
  output word_t sp_wr_data,
  output logic  pc_load,
  output word_t pc_new
);
  seq_st_e state;
  word_t   handler;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      handler <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) state <= ST_VEC;
        ST_VEC:  if (mem_ack) begin handler <= mem_rdata; state <= ST_PSR; end
        ST_PSR:  if (mem_ack) state <= ST_PPC;
        ST_PPC:  if (mem_ack) state <= ST_JMP;
        ST_JMP:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_VEC: begin mem_req = 1'b1; mem_addr = vec_addr(cap_vbr, cap_vec); end
      ST_PSR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = push_addr(cap_sp, 1); mem_wdata = cap_sr;
      end
      ST_PPC: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = push_addr(cap_sp, 2); mem_wdata = cap_pc;
      end
      default: ;
    endcase
    sp_wr_en   = mem_we && mem_ack;
    sp_wr_data = mem_addr;
    pc_load    = (state == ST_JMP);
    pc_new     = handler;
    idle       = (state == ST_IDLE);
    busy       = !idle;
  end

  // R8: an access waiting for its acknowledge keeps its request steady
  a_r8_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R10: the jump is a single pulse and ends the busy window
  a_r10_jump_ends: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy && !pc_load);

  // R12: nothing is driven while idle
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !pc_load && !sp_wr_en);

  // R9: stack updates land on one of the two push slots
  a_r9_sp_slots: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_en |-> (sp_wr_data == cap_sp - 32'd4) || (sp_wr_data == cap_sp - 32'd8));

  // R7: the handler is the data returned by the vector read
  a_r7_handler_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PSR && $past(state) == ST_VEC) |-> pc_new == $past(mem_rdata));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int VW         = 8,
  parameter int INSN_BYTES = 2,
  parameter logic [VW-1:0] VEC_GEN  = 8'd4,
  parameter logic [VW-1:0] VEC_SLOT = 8'd6,
  parameter logic [VW-1:0] VEC_DIV  = 8'd9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dec_valid,
  input  logic        dec_undef,
  input  logic        dec_fpu_op,
  input  logic        dec_bank_op,
  input  logic        dec_in_slot,
  input  logic [31:0] dec_pc,
  input  logic        cfg_fpu_present,
  input  logic        cfg_fpu_standby,
  input  logic        cfg_bank_present,
  input  logic        div_exc_req,
  input  logic [31:0] div_pc,
  input  logic [31:0] cur_sr,
  input  logic [31:0] cur_sp,
  input  logic [31:0] vec_base,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        sp_wr_en,
  output logic [31:0] sp_wr_data,
  output logic        pc_load,
  output logic [31:0] pc_new,
  output logic        busy
);
  logic  gen_hit, slot_hit, accept, idle;
  word_t cap_vec, cap_pc, cap_sr, cap_sp, cap_vbr;

  exc_classify u_cls (
    .dec_valid(dec_valid), .dec_undef(dec_undef), .dec_fpu_op(dec_fpu_op),
    .dec_bank_op(dec_bank_op), .dec_in_slot(dec_in_slot),
    .cfg_fpu_present(cfg_fpu_present), .cfg_fpu_standby(cfg_fpu_standby),
    .cfg_bank_present(cfg_bank_present),
    .gen_hit(gen_hit), .slot_hit(slot_hit)
  );

  exc_capture #(
    .VW(VW), .INSN_BYTES(INSN_BYTES),
    .VEC_GEN(VEC_GEN), .VEC_SLOT(VEC_SLOT), .VEC_DIV(VEC_DIV)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .gen_hit(gen_hit), .slot_hit(slot_hit), .div_req(div_exc_req),
    .dec_pc(dec_pc), .div_pc(div_pc), .sr_in(cur_sr), .sp_in(cur_sp),
    .vbr_in(vec_base), .accept(accept),
    .cap_vec(cap_vec), .cap_pc(cap_pc), .cap_sr(cap_sr),
    .cap_sp(cap_sp), .cap_vbr(cap_vbr)
  );

  exc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .cap_vec(cap_vec), .cap_pc(cap_pc), .cap_sr(cap_sr),
    .cap_sp(cap_sp), .cap_vbr(cap_vbr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .idle(idle), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .pc_load(pc_load), .pc_new(pc_new)
  );

  // R11: acceptance only happens from idle, so busy never re-rises mid-sequence
  a_r11_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pc_load) |=> busy);
endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        dec_valid = 0, dec_undef = 0, dec_fpu_op = 0, dec_bank_op = 0, dec_in_slot = 0;
  logic [31:0] dec_pc = 0, div_pc = 0, cur_sr = 0, cur_sp = 0, vec_base = 0;
  logic        cfg_fpu_present = 1, cfg_fpu_standby = 0, cfg_bank_present = 1;
  logic        div_exc_req = 0;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic        sp_wr_en, pc_load, busy;
  logic [31:0] sp_wr_data, pc_new;

  int checks = 0, fails = 0;
  bit done = 0;

  // access log filled by the memory responder
  int          rd_n, wr_n, ops, rd_pos, sp_cnt, pc_cnt, lat;
  logic [31:0] ra, sp_last, pc_val;
  logic [31:0] wa [4];
  logic [31:0] wd [4];

  always #4 clk = ~clk;

  exc_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_undef(dec_undef),
    .dec_fpu_op(dec_fpu_op), .dec_bank_op(dec_bank_op), .dec_in_slot(dec_in_slot),
    .dec_pc(dec_pc), .cfg_fpu_present(cfg_fpu_present),
    .cfg_fpu_standby(cfg_fpu_standby), .cfg_bank_present(cfg_bank_present),
    .div_exc_req(div_exc_req), .div_pc(div_pc), .cur_sr(cur_sr), .cur_sp(cur_sp),
    .vec_base(vec_base), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .pc_load(pc_load),
    .pc_new(pc_new), .busy(busy)
  );

  function automatic logic [31:0] table_word(input logic [31:0] a);
    return {a[27:0], 4'h0} ^ 32'h4000_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    rd_n = 0; wr_n = 0; ops = 0; rd_pos = -1; sp_cnt = 0; pc_cnt = 0;
    ra = 0; sp_last = 0; pc_val = 0;
  endtask

  // memory responder and strobe monitor, acting at the falling edge
  initial begin
    lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (lat > 0) lat--;
        else begin
          if (mem_we) begin
            if (wr_n < 4) begin wa[wr_n] = mem_addr; wd[wr_n] = mem_wdata; end
            wr_n++;
          end else begin
            rd_pos = ops; rd_n++; ra = mem_addr; mem_rdata = table_word(mem_addr);
          end
          ops++;
          mem_ack = 1;
          lat = $urandom % 3;
        end
      end
      #1;
      if (sp_wr_en) begin sp_cnt++; sp_last = sp_wr_data; end
      if (pc_load) begin pc_cnt++; pc_val = pc_new; end
    end
  end

  task automatic run_case(input bit un, input bit fo, input bit bo, input bit sl,
                          input bit fp, input bit fs, input bit bp, input bit dv,
                          input bit inject, input string none_tag);
    logic [31:0] dpc, vpc, sp, sr, vb, exp_pc, exp_vec;
    bit          u, hit;
    string       pc_tag;
    int          guard;
    dpc = $urandom & ~32'h1; vpc = $urandom & ~32'h1;
    sp  = $urandom & ~32'h3; sr  = $urandom; vb = $urandom & ~32'h3;
    // expected kind from the requirements
    u   = un | (fo & (!fp | fs)) | (bo & !bp);
    hit = 1;
    if (u && !sl)      begin exp_vec = 4; exp_pc = dpc;     pc_tag = "R1"; end
    else if (u && sl)  begin exp_vec = 6; exp_pc = dpc - 2; pc_tag = "R2"; end
    else if (dv)       begin exp_vec = 9; exp_pc = vpc;     pc_tag = "R5"; end
    else               begin hit = 0; exp_vec = 0; exp_pc = 0; pc_tag = none_tag; end

    @(negedge clk);
    clear_log();
    dec_valid = 1; dec_undef = un; dec_fpu_op = fo; dec_bank_op = bo; dec_in_slot = sl;
    cfg_fpu_present = fp; cfg_fpu_standby = fs; cfg_bank_present = bp;
    div_exc_req = dv; dec_pc = dpc; div_pc = vpc; cur_sp = sp; cur_sr = sr; vec_base = vb;
    @(negedge clk);
    dec_valid = 0; dec_undef = 0; dec_fpu_op = 0; dec_bank_op = 0; dec_in_slot = 0;
    div_exc_req = 0;
    #2;
    chk(busy == hit, hit ? "R10 busy after accept" : {none_tag, " no accept"}, 32'(busy), 32'(hit));
    guard = 0;
    while (busy && guard < 100) begin
      @(negedge clk);
      guard++;
      if (inject && guard == 2) begin
        dec_valid = 1; dec_undef = 1; div_exc_req = 1;
        @(negedge clk);
        dec_valid = 0; dec_undef = 0; div_exc_req = 0;
      end
      #2;
    end
    repeat (4) @(negedge clk);
    #2;
    if (!hit) begin
      chk(ops == 0 && pc_cnt == 0 && sp_cnt == 0, {none_tag, " no exception"}, 32'(ops), 0);
      return;
    end
    chk(rd_n == 1 && rd_pos == 0, "R8 vector read first", 32'(rd_pos), 0);
    chk(ra == vb + 4 * exp_vec, "R7 vector address", ra, vb + 4 * exp_vec);
    chk(wr_n == 2, inject ? "R11 write count" : "R8 write count", 32'(wr_n), 2);
    chk(wa[0] == sp - 4 && wd[0] == sr, "R8 SR push", wd[0], sr);
    chk(wa[1] == sp - 8, "R8 PC push address", wa[1], sp - 8);
    chk(wd[1] == exp_pc, {pc_tag, " saved PC"}, wd[1], exp_pc);
    chk(sp_cnt == 2 && sp_last == sp - 8, "R9 final SP", sp_last, sp - 8);
    chk(pc_cnt == 1, inject ? "R11 one jump" : "R10 one jump", 32'(pc_cnt), 1);
    chk(pc_val == table_word(vb + 4 * exp_vec), "R7 new PC", pc_val, table_word(vb + 4 * exp_vec));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_log();
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !mem_req && !pc_load && !sp_wr_en, "R12 reset outputs", 32'(busy), 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!busy && !mem_req && !pc_load && !sp_wr_en, "R12 after reset", 32'(busy), 0);

    // directed corners: un fo bo sl fp fs bp dv inject
    run_case(1,0,0,0, 1,0,1, 0, 0, "R1");
    run_case(1,0,0,1, 1,0,1, 0, 0, "R2");
    run_case(0,1,0,0, 0,0,1, 0, 0, "R3");
    run_case(0,1,0,1, 1,1,1, 0, 0, "R3");
    run_case(0,1,0,0, 1,0,1, 0, 0, "R3");
    run_case(0,0,1,0, 1,0,0, 0, 0, "R4");
    run_case(0,0,1,0, 1,0,1, 0, 0, "R4");
    run_case(0,0,0,0, 1,0,1, 1, 0, "R5");
    run_case(1,0,0,0, 1,0,1, 1, 0, "R6");
    run_case(1,0,0,1, 1,0,1, 1, 0, "R6");
    run_case(0,0,0,0, 1,0,1, 1, 1, "R11");
    run_case(1,0,0,1, 1,0,1, 0, 1, "R11");

    for (int i = 0; i < 40; i++) begin
      logic [8:0] r;
      r = 9'($urandom);
      run_case(r[0] & r[8], r[1], r[2], r[3], r[4], r[5], r[6], r[7],
               ($urandom % 4) == 0, "R6 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule